// File: doc/BRIEF.md
# Triangular-Dither Sample Requantizer

This block narrows a stream of 16-bit two's-complement samples to 8 bits. Before the precision is dropped, a pseudo-random offset with a triangular probability density is added to each sample. The offset spans one output step on each side of zero. The dithered value is then rounded to the nearest 8-bit level and limited to the signed 8-bit range. Because of the dither, the quantisation error no longer follows the signal. A constant input that lies between two output levels comes out as a mix of neighbouring codes, and their average recovers the fractional part.

The triangular offset is the centred sum of two independent uniform 8-bit values. Each value comes from its own maximal-length shift-register generator, and the two generators use different feedback polynomials. A generator advances only when a sample is accepted, so the dither sequence is tied to the data and not to idle clock cycles. A bypass input forces the offset to zero. The block then does plain round-to-nearest, which is useful for comparison and for exact checking.

Top module: `dither_requant`

## Requirements
- R1: Each cycle with `in_valid` high produces exactly one output: `out_valid` is high on the following cycle together with `out_sample`. After a cycle with `in_valid` low, `out_valid` is low. Reset clears `out_valid` and `out_sample` to 0.
- R2: With `bypass` high, `out_sample` equals floor(x/256 + 0.5), where x is the signed value of `in_sample`. An exact half step rounds upward, so x = -128 gives 0 and x = 128 gives 1.
- R3: With `bypass` high, a rounded result above +127 is output as +127 (8'h7F), and one below -128 is output as -128 (8'h80).
- R4: With `bypass` low, the output differs by at most one level from the unclamped bypass result, and it is then clamped to [-128, +127].
- R5: With `bypass` low and a constant input, the mean of 2040 consecutive outputs is within 0.2 output LSB of x/256.
- R6: With `bypass` low and a constant input, the variance of those outputs lies between 0.15 and 0.35 LSB² at every tested level, whole or fractional.
- R7: The dither sequence advances only on accepted samples. The same series of accepted inputs after reset gives the same series of outputs, whether or not idle cycles are mixed in.
- R8: With `bypass` low, a full-scale positive input (16'h7FFF) always gives +127, and a full-scale negative input (16'h8000) gives only -128 or -127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_sample | input | 16 | Two's-complement input sample |
| bypass | input | 1 | High: no dither, plain rounding |
| out_valid | output | 1 | Output sample present |
| out_sample | output | 8 | Two's-complement requantized sample |

## Verification
A bypassed sweep over all 65536 input codes pins down the rounding point, the upward tie-break and both clamp limits exactly. A dithered sweep over the whole range confirms that the noise never moves a result more than one level. Long constant-input runs at whole, half and odd fractional levels measure mean and variance: the mean shows the fraction is preserved, and a flat variance shows the noise does not depend on level. A run repeated with idle gaps inserted tells a generator stepped per sample from one stepped per clock.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // Round to nearest with ties upward, dividing by 2**sh.
  function automatic int round_half_up(input int v, input int sh);
    return (v + (1 <<< (sh - 1))) >>> sh;
  endfunction

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/dq_lfsr.sv
module dq_lfsr #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter int unsigned STEPS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [W-1:0] value
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_next;

  // Several single-bit shifts per accepted sample give fresh bits each time.
  function automatic logic [W-1:0] step_n(input logic [W-1:0] s_in);
    logic [W-1:0] s;
    s = s_in;
    for (int i = 0; i < int'(STEPS); i++) begin
      s = {s[W-2:0], ^(s & TAPS)};
    end
    return s;
  endfunction

  always_comb state_next = step_n(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= state_next;
  end

  assign value = state_q;

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state_q));

  a_r7_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/dq_tpdf.sv
module dq_tpdf #(
  parameter int unsigned UW = 8,
  localparam int unsigned DW = UW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  output logic signed [DW-1:0] dither
);

  logic [UW-1:0] uni_a;
  logic [UW-1:0] uni_b;

  dq_lfsr #(.W(UW), .TAPS(UW'(8'hB8)), .SEED(UW'(8'h01)), .STEPS(UW)) gen_a (
    .clk(clk), .rst_n(rst_n), .advance(advance), .value(uni_a));

  dq_lfsr #(.W(UW), .TAPS(UW'(8'hB4)), .SEED(UW'(8'h5A)), .STEPS(UW)) gen_b (
    .clk(clk), .rst_n(rst_n), .advance(advance), .value(uni_b));

  // Sum of two uniforms is triangular; subtract the mean to centre it on zero.
  function automatic int centre_sum(input logic [UW-1:0] a, input logic [UW-1:0] b);
    return int'(a) + int'(b) - (1 << UW);
  endfunction

  always_comb dither = DW'(centre_sum(uni_a, uni_b));

  a_r4_dither_span: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dither) > -(1 << UW)) && (int'(dither) < (1 << UW)));

endmodule

// File: rtl/dq_requant.sv
module dq_requant #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 8,
  localparam int unsigned SH   = IN_W - OUT_W,
  localparam int unsigned DW   = SH + 2
) (
  input  logic [IN_W-1:0]      sample,
  input  logic signed [DW-1:0] dither,
  input  logic                 bypass,
  output logic [OUT_W-1:0]     result,
  output logic                 sat_hi,
  output logic                 sat_lo
);
  import dq_pkg::*;

  localparam int OMAX = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN = -(1 << (OUT_W - 1));

  int sum_v;
  int rnd_v;

  always_comb begin
    sum_v  = int'($signed(sample)) + (bypass ? 0 : int'(dither));
    rnd_v  = round_half_up(sum_v, int'(SH));
    sat_hi = rnd_v > OMAX;
    sat_lo = rnd_v < OMIN;
    result = OUT_W'(clamp_int(rnd_v, OMIN, OMAX));
  end

endmodule

// File: rtl/dither_requant.sv
module dither_requant #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  input  logic             bypass,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sample
);
  import dq_pkg::*;

  localparam int unsigned SH = IN_W - OUT_W;
  localparam int unsigned DW = SH + 2;
  localparam int OMAX = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN = -(1 << (OUT_W - 1));

  logic signed [DW-1:0] dither;
  logic [OUT_W-1:0]     rq_result;
  logic                 rq_sat_hi;
  logic                 rq_sat_lo;
  logic                 accept;

  assign accept = in_valid;

  dq_tpdf #(.UW(SH)) noise (
    .clk(clk), .rst_n(rst_n), .advance(accept), .dither(dither));

  dq_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) quant (
    .sample(in_sample), .dither(dither), .bypass(bypass),
    .result(rq_result), .sat_hi(rq_sat_hi), .sat_lo(rq_sat_lo));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= accept;
      if (accept) out_sample <= rq_result;
    end
  end

  // Distance check against undithered rounding of the accepted sample.
  function automatic bit near_plain(input logic [IN_W-1:0] x, input logic [OUT_W-1:0] y);
    int p;
    int o;
    p = round_half_up(int'($signed(x)), int'(SH));
    o = int'($signed(y));
    return (o >= clamp_int(p - 1, OMIN, OMAX)) && (o <= clamp_int(p + 1, OMIN, OMAX));
  endfunction

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r4_within_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> near_plain($past(in_sample), out_sample));

  a_r3_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rq_sat_hi) |=> (out_sample == OUT_W'(OMAX)));

  a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rq_sat_lo) |=> (out_sample == OUT_W'(OMIN)));

endmodule

// File: tb/dither_requant_test.sv
module dither_requant_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic       bypass = 1'b0;
  logic       out_valid;
  logic [7:0] out_sample;

  int checks = 0;
  int errors = 0;
  int rec_a [300];

  always #2 clk = ~clk;

  dither_requant uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .bypass(bypass), .out_valid(out_valid), .out_sample(out_sample));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int plain_round(input int x);
    return int'($floor(real'(x) / 256.0 + 0.5));
  endfunction

  function automatic int limit8(input int v);
    return (v > 127) ? 127 : ((v < -128) ? -128 : v);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present one sample, return the registered output one edge later.
  task automatic send(input int x, input bit byp, output int y, output bit v);
    @(negedge clk);
    in_valid = 1'b1; in_sample = 16'(x); bypass = byp;
    @(posedge clk); #1;
    y = int'($signed(out_sample)); v = out_valid;
  endtask

  task automatic idle(output bit v);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    v = out_valid;
  endtask

  task automatic stats(input int x);
    real s, sq, m, var_v;
    int y; bit v;
    s = 0.0; sq = 0.0;
    for (int i = 0; i < 2040; i++) begin
      send(x, 1'b0, y, v);
      s += real'(y); sq += real'(y) * real'(y);
    end
    m = s / 2040.0;
    var_v = sq / 2040.0 - m * m;
    // R5: long-run mean tracks the fractional input
    check((m - real'(x) / 256.0) < 0.2 && (m - real'(x) / 256.0) > -0.2, "R5",
          int'(m * 1000.0), int'(real'(x) / 256.0 * 1000.0));
    // R6: noise power independent of level
    check(var_v > 0.15 && var_v < 0.35, "R6", int'(var_v * 1000.0), 250);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int y; bit v;
    do_reset();
    @(posedge clk); #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_sample == 8'h00, "R1", int'(out_sample), 0);

    // R2/R3: exhaustive bypassed sweep
    for (int x = -32768; x < 32768; x++) begin
      send(x, 1'b1, y, v);
      check(v, "R1", int'(v), 1);
      if (plain_round(x) > 127 || plain_round(x) < -128)
        check(y == limit8(plain_round(x)), "R3", y, limit8(plain_round(x)));
      else
        check(y == plain_round(x), "R2", y, plain_round(x));
    end
    send(-128, 1'b1, y, v);
    check(y == 0, "R2", y, 0);
    send(128, 1'b1, y, v);
    check(y == 1, "R2", y, 1);
    idle(v);
    check(v == 1'b0, "R1", int'(v), 0);

    // R4: dithered sweep stays within one level
    for (int x = -32768; x < 32768; x += 7) begin
      int p;
      send(x, 1'b0, y, v);
      p = plain_round(x);
      check(y >= limit8(p - 1) && y <= limit8(p + 1) && y <= 127 && y >= -128, "R4", y, p);
    end

    // R5/R6: constant-input statistics at whole and fractional levels
    stats(0);
    stats(5 * 256 + 64);
    stats(-3 * 256 + 128);
    stats(77);
    stats(-200);
    stats(100 * 256 + 200);

    // R8: dithered full scale
    for (int i = 0; i < 300; i++) begin
      send(32767, 1'b0, y, v);
      check(y == 127, "R8", y, 127);
    end
    for (int i = 0; i < 300; i++) begin
      send(-32768, 1'b0, y, v);
      check(y == -128 || y == -127, "R8", y, -128);
    end

    // R7: gaps must not move the dither sequence
    do_reset();
    for (int i = 0; i < 300; i++) begin
      send(100 + 3 * i, 1'b0, y, v);
      rec_a[i] = y;
    end
    do_reset();
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 1) begin
        idle(v);
        check(v == 1'b0, "R1", int'(v), 0);
        idle(v);
      end
      send(100 + 3 * i, 1'b0, y, v);
      check(y == rec_a[i], "R7", y, rec_a[i]);
    end

    @(negedge clk);
    in_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule